// File: doc/BRIEF.md
# Pin-Routed Serial Peripheral Master

This block is a register-programmed SPI master that shares one bank of general-purpose lines among several peripherals. Each peripheral slot holds its own setup: which bank lines carry select, serial clock, outgoing data and incoming data, how many bits a transfer moves, and on which clock edge data is launched and sampled. A transfer register names the active slot and sets the serial clock rate. A write to the start register hands the engine a left-justified word, and the status register reports when the engine is idle and what it shifted in.

Software programs the slots once. For each transfer it selects a slot, writes the payload and polls status until ready returns. The engine copies the slot setup and the rate when a transfer starts, so changes to the registers during a transfer do not disturb it. Routing follows the selected slot while idle, and the copied slot while busy. A length field of 0 or above 32 is treated as 32.

Top module: `gpio_spi_master`

## Requirements
- R1: The word at offset 0x00 is read-only and returns the number of peripheral slots (parameter NUM_PERIPH) in bits 3:0, zero above.
- R2: Slot p has a register at offset 0x10 + 4*p. Bits 27:0 read back as written and bits 31:28 read as zero. Field layout: bit 27 launch-on-falling, bit 26 sample-on-rising, 25:20 length, 19:15 select line, 14:10 data-in line, 9:5 data-out line, 4:0 clock line.
- R3: The register at offset 0x04 holds the slot index in bits 17:16 and the rate divider in bits 15:0, and reads back as written.
- R4: A write to offset 0x08 while idle starts a transfer of N bits (N from bits 25:20 of the slot register). Bits 31 down to 32-N of the written word appear on the data-out line, most significant first.
- R5: With bit 27 clear, data out changes on rising serial clock edges and is stable at each falling edge. With bit 27 set, data out changes on falling edges and is stable at each rising edge.
- R6: With bit 26 clear, data in is sampled on falling edges, and with it set on rising edges. Status bits 23:0 at offset 0x0C hold the last 24 sampled bits, the final bit in bit 0.
- R7: Status bit 24 (ready) is 1 after reset. It is 0 from the clock edge that accepts a start write, and becomes 1 again exactly 2*N*(D+1)+1 clock edges after that edge, where D is the divider.
- R8: Each serial clock half period lasts D+1 system clocks. The serial clock is low when idle. The select line is high when idle and low during every serial clock edge of a transfer.
- R9: Select, serial clock and data out are driven on the line numbers chosen by the active slot, and data in is taken from the chosen data-in line.
- R10: The output enable is set for exactly the select, clock and data-out lines of the active slot, and clear for every other line.
- R11: A start write while a transfer is running has no effect on that transfer's data, timing or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | AW | Register byte address |
| bus_wdata_i | input | 32 | Register write data |
| bus_we_i | input | 1 | Register write strobe, one cycle per write |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| gpio_i | input | GPIO_W | Line input values |
| gpio_o | output | GPIO_W | Line output values |
| gpio_oe_o | output | GPIO_W | Line output enables |

## Verification
The assertions take for granted that the slot count is at most four, that chosen line numbers are below GPIO_W, and that the data-in line is stable around each sampling edge, because the engine samples it without resynchronization. The stimulus keeps within this. It uses only line numbers below eight. It gives each role of a slot its own line. It acts as the peripheral and changes data in only on the system clock edge after each sampling edge has been seen, which is at least one system clock before the next sampling edge. A sweep covers every edge mode, a range of lengths from 1 to 32 and two divider values, and rotates the slot and the line assignment from one transfer to the next.

// File: rtl/gspi_pkg.sv
`timescale 1ns/1ps
package gspi_pkg;
  typedef struct packed {
    logic       launch_fall;
    logic       cap_rise;
    logic [5:0] nbits;
    logic [4:0] cs_pin;
    logic [4:0] din_pin;
    logic [4:0] dout_pin;
    logic [4:0] clk_pin;
  } pcfg_t;

  localparam int unsigned PCFG_W = $bits(pcfg_t);

  // word indices (byte offset / 4)
  localparam int unsigned WI_INFO = 0;
  localparam int unsigned WI_XFER = 1;
  localparam int unsigned WI_GO   = 2;
  localparam int unsigned WI_STAT = 3;
  localparam int unsigned WI_PCFG = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} st_e;
endpackage

// File: rtl/gspi_regs.sv
`timescale 1ns/1ps
module gspi_regs
  import gspi_pkg::*;
#(
  parameter int unsigned NUM_PERIPH = 4,
  parameter int unsigned AW         = 8,
  localparam int unsigned WA        = AW - 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  input  logic          we_i,
  input  logic          ready_i,
  input  logic [23:0]   rx_i,
  output logic [31:0]   rdata_o,
  output logic          go_o,
  output pcfg_t         cur_cfg_o,
  output logic [15:0]   div_o
);
  logic [WA-1:0] widx;
  logic          aligned;
  logic          wr;
  pcfg_t         cfg_q [NUM_PERIPH];
  logic [1:0]    sel_q;
  logic [15:0]   div_q;

  assign widx    = addr_i[AW-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign wr      = we_i && aligned;

  for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 cfg_q[p] <= '0;
      else if (wr && widx == WA'(WI_PCFG + p))     cfg_q[p] <= pcfg_t'(wdata_i[PCFG_W-1:0]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      div_q <= '0;
    end else if (wr && widx == WA'(WI_XFER)) begin
      sel_q <= wdata_i[17:16];
      div_q <= wdata_i[15:0];
    end
  end

  assign go_o  = wr && (widx == WA'(WI_GO));
  assign div_o = div_q;

  always_comb begin
    cur_cfg_o = '0;
    for (int p = 0; p < NUM_PERIPH; p++)
      if (sel_q == 2'(p)) cur_cfg_o = cfg_q[p];
  end

  always_comb begin
    rdata_o = '0;
    if (aligned) begin
      if (widx == WA'(WI_INFO))      rdata_o = {28'd0, 4'(NUM_PERIPH)};
      else if (widx == WA'(WI_XFER)) rdata_o = {14'd0, sel_q, div_q};
      else if (widx == WA'(WI_STAT)) rdata_o = {7'd0, ready_i, rx_i};
      for (int p = 0; p < NUM_PERIPH; p++)
        if (widx == WA'(WI_PCFG + p)) rdata_o = {{(32-PCFG_W){1'b0}}, cfg_q[p]};
    end
  end

  initial assert (NUM_PERIPH >= 1 && NUM_PERIPH <= 4) else $error("slot count out of range");
endmodule

// File: rtl/gspi_engine.sv
`timescale 1ns/1ps
module gspi_engine
  import gspi_pkg::*;
#(
  parameter int unsigned GPIO_W = 8,
  parameter int unsigned DIV_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [31:0]       wdata_i,
  input  pcfg_t             cfg_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [GPIO_W-1:0] gpio_i,
  output logic              ready_o,
  output logic              busy_o,
  output logic              sclk_o,
  output logic              cs_n_o,
  output logic              dout_o,
  output logic [23:0]       rx_o,
  output pcfg_t             act_cfg_o
);
  st_e              st_q;
  pcfg_t            cfg_q;
  logic [DIV_W-1:0] div_q, hc_q;
  logic [6:0]       hp_q, nb2, last_hp;
  logic [31:0]      tx_q;
  logic [23:0]      rx_q;
  logic             sclk_q, cs_n_q, din, half_end;

  assign nb2     = (cfg_q.nbits == 6'd0 || cfg_q.nbits > 6'd32) ? 7'd64 : {cfg_q.nbits, 1'b0};
  assign last_hp = nb2 - 7'd1;

  always_comb begin
    din = 1'b0;
    for (int g = 0; g < GPIO_W; g++)
      if (cfg_q.din_pin == 5'(g)) din = gpio_i[g];
  end

  assign half_end = (st_q == ST_RUN) && (hc_q == div_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cfg_q  <= '0;
      div_q  <= '0;
      hc_q   <= '0;
      hp_q   <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      sclk_q <= 1'b0;
      cs_n_q <= 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: if (go_i) begin
          st_q   <= ST_RUN;
          cfg_q  <= cfg_i;
          div_q  <= div_i;
          tx_q   <= wdata_i;
          rx_q   <= '0;
          hc_q   <= '0;
          hp_q   <= '0;
          sclk_q <= 1'b0;
          cs_n_q <= 1'b0;
        end
        ST_RUN: if (half_end) begin
          hc_q   <= '0;
          hp_q   <= hp_q + 7'd1;
          sclk_q <= ~hp_q[0];
          if (!hp_q[0]) begin  // rising edge
            if (cfg_q.cap_rise) rx_q <= {rx_q[22:0], din};
            if (!cfg_q.launch_fall && hp_q != 7'd0) tx_q <= tx_q << 1;
          end else begin       // falling edge
            if (!cfg_q.cap_rise) rx_q <= {rx_q[22:0], din};
            if (cfg_q.launch_fall) tx_q <= tx_q << 1;
            if (hp_q == last_hp) begin
              st_q   <= ST_DONE;
              cs_n_q <= 1'b1;
            end
          end
        end else begin
          hc_q <= hc_q + 1'b1;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o   = (st_q == ST_IDLE);
  assign busy_o    = ~ready_o;
  assign sclk_o    = sclk_q;
  assign cs_n_o    = cs_n_q;
  assign dout_o    = busy_o & tx_q[31];
  assign rx_o      = rx_q;
  assign act_cfg_o = cfg_q;

  p_go_clears_ready_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i && ready_o |=> !ready_o);
  p_busy_go_ignored_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i && !ready_o |=> $stable(cfg_q) && $stable(div_q));
  p_cs_low_running_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_RUN |-> !cs_n_q);
  p_idle_levels_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !sclk_q && cs_n_q);
  p_half_count_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_RUN |-> hc_q <= div_q);
endmodule

// File: rtl/gspi_pinmux.sv
`timescale 1ns/1ps
module gspi_pinmux
  import gspi_pkg::*;
#(
  parameter int unsigned GPIO_W = 8
) (
  input  pcfg_t             cfg_i,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic              dout_i,
  output logic [GPIO_W-1:0] gpio_o,
  output logic [GPIO_W-1:0] gpio_oe_o
);
  // role priority on a shared line: select, then clock, then data out
  for (genvar g = 0; g < GPIO_W; g++) begin : g_line
    always_comb begin
      if (cfg_i.cs_pin == 5'(g)) begin
        gpio_oe_o[g] = 1'b1;
        gpio_o[g]    = cs_n_i;
      end else if (cfg_i.clk_pin == 5'(g)) begin
        gpio_oe_o[g] = 1'b1;
        gpio_o[g]    = sclk_i;
      end else if (cfg_i.dout_pin == 5'(g)) begin
        gpio_oe_o[g] = 1'b1;
        gpio_o[g]    = dout_i;
      end else begin
        gpio_oe_o[g] = 1'b0;
        gpio_o[g]    = 1'b0;
      end
    end
  end
endmodule

// File: rtl/gpio_spi_master.sv
`timescale 1ns/1ps
module gpio_spi_master
  import gspi_pkg::*;
#(
  parameter int unsigned NUM_PERIPH = 4,
  parameter int unsigned GPIO_W     = 8,
  parameter int unsigned AW         = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  input  logic              bus_we_i,
  output logic [31:0]       bus_rdata_o,
  input  logic [GPIO_W-1:0] gpio_i,
  output logic [GPIO_W-1:0] gpio_o,
  output logic [GPIO_W-1:0] gpio_oe_o
);
  logic        go, ready, busy, sclk, cs_n, dout;
  logic [15:0] div;
  logic [23:0] rx;
  pcfg_t       cur_cfg, act_cfg, route_cfg;

  gspi_regs #(.NUM_PERIPH(NUM_PERIPH), .AW(AW)) i_regs (
    .clk_i, .rst_ni,
    .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .we_i(bus_we_i),
    .ready_i(ready), .rx_i(rx),
    .rdata_o(bus_rdata_o), .go_o(go), .cur_cfg_o(cur_cfg), .div_o(div)
  );

  gspi_engine #(.GPIO_W(GPIO_W), .DIV_W(16)) i_engine (
    .clk_i, .rst_ni,
    .go_i(go), .wdata_i(bus_wdata_i), .cfg_i(cur_cfg), .div_i(div), .gpio_i(gpio_i),
    .ready_o(ready), .busy_o(busy), .sclk_o(sclk), .cs_n_o(cs_n), .dout_o(dout),
    .rx_o(rx), .act_cfg_o(act_cfg)
  );

  assign route_cfg = busy ? act_cfg : cur_cfg;

  gspi_pinmux #(.GPIO_W(GPIO_W)) i_pinmux (
    .cfg_i(route_cfg), .cs_n_i(cs_n), .sclk_i(sclk), .dout_i(dout),
    .gpio_o(gpio_o), .gpio_oe_o(gpio_oe_o)
  );

  p_oe_roles_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(gpio_oe_o) <= 3);
  p_route_held_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && $past(busy) |-> $stable(gpio_oe_o));
endmodule

// File: tb/test_gpio_spi_master.sv
`timescale 1ns/1ps
module test_gpio_spi_master;
  localparam int unsigned GW = 8;
  localparam logic [7:0] A_INFO = 8'h00, A_XFER = 8'h04, A_GO = 8'h08, A_STAT = 8'h0C, A_PCFG = 8'h10;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [7:0]    addr = A_STAT;
  logic [31:0]   wdata = '0;
  logic          we = 1'b0;
  logic [31:0]   rdata;
  logic [GW-1:0] gin = '0, gout, goe;
  int tests = 0, fails = 0;

  gpio_spi_master #(.NUM_PERIPH(4), .GPIO_W(GW), .AW(8)) i_gpio_spi_master (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_we_i(we),
    .bus_rdata_o(rdata), .gpio_i(gin), .gpio_o(gout), .gpio_oe_o(goe)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0; addr = A_STAT;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
    addr = A_STAT;
  endtask

  task automatic xfer(input int p, input int cs, input int ck, input int dq, input int di,
                      input bit lf, input bit cr, input int n, input int dv,
                      input logic [31:0] word, input logic [31:0] miso, input bit extra_go);
    logic [31:0] cfgw, r, mosi, mask;
    logic [GW-1:0] exp_oe;
    int c, last_tog, nm, ncap, t_exp;
    bit gap_bad, cs_bad, prev, s;
    cfgw = {4'd0, lf, cr, 6'(n), 5'(cs), 5'(di), 5'(dq), 5'(ck)};
    wr(A_PCFG + 8'(4 * p), cfgw);
    wr(A_XFER, {14'd0, 2'(p), 16'(dv)});
    rd(A_PCFG + 8'(4 * p), r);
    chk(r == cfgw, "R2 slot readback", r, cfgw);
    rd(A_XFER, r);
    chk(r == {14'd0, 2'(p), 16'(dv)}, "R3 transfer reg readback", r, {14'd0, 2'(p), 16'(dv)});
    exp_oe = '0; exp_oe[cs] = 1'b1; exp_oe[ck] = 1'b1; exp_oe[dq] = 1'b1;
    @(negedge clk); #1;
    chk(goe == exp_oe, "R10 enables idle", goe, exp_oe);
    chk(gout[cs] == 1'b1 && gout[ck] == 1'b0, "R8 R9 idle levels", {gout[cs], gout[ck]}, 2'b10);
    gin = ~gin;
    gin[di] = miso[n-1];
    @(negedge clk); addr = A_GO; wdata = word; we = 1'b1;
    @(negedge clk); we = 1'b0; addr = A_STAT;
    c = 0; last_tog = 0; nm = 0; ncap = 0; mosi = '0;
    gap_bad = 0; cs_bad = 0; prev = 1'b0;
    t_exp = 2 * n * (dv + 1) + 1;
    while (c < 5000) begin
      #1;
      if (extra_go && c == 4) begin we = 1'b0; addr = A_STAT; #1; end
      if (rdata[24]) break;
      s = gout[ck];
      if (s != prev) begin
        if (c - last_tog != dv + 1) gap_bad = 1;
        last_tog = c;
        if (s) begin
          if (gout[cs] !== 1'b0) cs_bad = 1;
          if (lf) begin mosi = {mosi[30:0], gout[dq]}; nm++; end
          if (cr) begin ncap++; if (ncap < n) gin[di] = miso[n-1-ncap]; end
        end else begin
          if (!lf) begin mosi = {mosi[30:0], gout[dq]}; nm++; end
          if (!cr) begin ncap++; if (ncap < n) gin[di] = miso[n-1-ncap]; end
        end
        prev = s;
      end
      if (extra_go && c == 3) begin addr = A_GO; wdata = ~word; we = 1'b1; end
      @(negedge clk);
      c++;
    end
    mask = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1);
    chk(c == t_exp, extra_go ? "R11 timing with extra start" : "R7 ready return",
        64'(c), 64'(t_exp));
    chk((mosi & mask) == ((word >> (32 - n)) & mask) && nm == n,
        extra_go ? "R11 data with extra start" : "R4 R5 data out", mosi & mask,
        (word >> (32 - n)) & mask);
    chk(!gap_bad && !cs_bad && ncap == n, "R8 half period and select", {gap_bad, cs_bad, 8'(ncap)},
        {2'b00, 8'(n)});
    rd(A_STAT, r);
    chk(r[24] == 1'b1 && r[23:0] == (miso & mask & 32'h00FF_FFFF),
        "R6 R9 captured data", r, {7'd0, 1'b1, 24'(miso & mask)});
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int k, lens[7];
    lens = '{1, 3, 8, 17, 24, 31, 32};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(A_STAT, r);
    chk(r == 32'h0100_0000, "R7 reset status", r, 32'h0100_0000);
    @(negedge clk); #1;
    chk(goe == 8'h01 && gout == 8'h01, "R10 reset routing", {goe, gout}, 16'h0101);
    rd(A_INFO, r);
    chk(r == 32'd4, "R1 slot count", r, 32'd4);
    wr(A_INFO, 32'hFFFF_FFFF);
    rd(A_INFO, r);
    chk(r == 32'd4, "R1 write ignored", r, 32'd4);
    wr(A_PCFG + 8'h4, 32'hFFFF_FFFF);
    rd(A_PCFG + 8'h4, r);
    chk(r == 32'h0FFF_FFFF, "R2 upper bits zero", r, 32'h0FFF_FFFF);
    k = 0;
    for (int lf = 0; lf < 2; lf++)
      for (int cr = 0; cr < 2; cr++)
        for (int li = 0; li < 7; li++)
          for (int dv = 0; dv < 4; dv += 3) begin
            xfer(k % 4, k % 8, (k + 1) % 8, (k + 3) % 8, (k + 5) % 8, lf[0], cr[0], lens[li], dv,
                 32'hA5C3_1E69 ^ (32'(k) * 32'h9E37_79B9), 32'h3C96_5AF1 ^ (32'(k) * 32'h0101_0F07), 1'b0);
            k++;
          end
    xfer(2, 6, 0, 3, 5, 1'b1, 1'b0, 8, 1, 32'hC300_0000, 32'h0000_005A, 1'b1);
    xfer(3, 1, 2, 4, 7, 1'b0, 1'b1, 12, 0, 32'h8F10_0000, 32'h0000_0A5C, 1'b1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule